// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block sits between ten grouped interrupt request lines and a processor. Each line carries its own enable bit and a one-bit level select. Vectors 1 and 2 may use the top ("highest") level. The other eight vectors may only reach the middle ("high") level. A line with its select cleared runs at the low level. Each cycle the block arbitrates among the enabled, pending lines. It raises a one-cycle acknowledge together with the winner's vector address, but only when the winner's level is strictly above the level now being serviced.

Every acknowledge pushes the granted level onto a small level stack, and its top is the current service level. A return pulse from the processor pops the stack, which restores the interrupted level. Requests are level-sensitive: the requester holds its line until the service routine clears it. A global enable gates all granting without discarding anything that is pending. All pins are plain control signals; there is no data stream, so no valid/ready handshake applies.

Top module: `pvic_top`

## Requirements
- R1: After reset, `ack` is 0, `vec_addr` is 0 and `svc_level` is 0 (nothing in service).
- R2: The vector address for line index i (0..9) is 0x03 + 8*i, giving 0x03 up to 0x4B, and is valid while `ack` is high.
- R3: Level encoding on `svc_level` is 0 = idle, 1 = low, 2 = high, 3 = highest. A line with `irq_lvl_sel[i]` = 0 runs at low. With the bit set, lines 0 and 1 run at highest and lines 2..9 run at high.
- R4: Among pending enabled lines, the one with the greatest level wins, regardless of index.
- R5: Among pending lines at the same greatest level, the lowest index (lowest vector address) wins.
- R6: A request whose level is equal to or below `svc_level` is not acknowledged.
- R7: A request above `svc_level` is acknowledged even during service (nesting). `svc_level` then becomes the new level.
- R8: `ack` is a single-cycle pulse. It appears the cycle after the inputs that caused it, and from that cycle `svc_level` shows the pushed level.
- R9: A `reti` pulse pops one level, restoring the previous `svc_level` on the next cycle. No acknowledge is issued for the cycle in which `reti` is sampled; pending requests are arbitrated again on the following cycle.
- R10: While `glb_en` is 0 no acknowledge is issued. A request still held when `glb_en` returns to 1 is then granted.
- R11: A line with `irq_en[i]` = 0 is never granted, whatever its request.
- R12: A `reti` while `svc_level` is 0 has no effect; `svc_level` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global grant enable |
| irq_req | input | 10 | Level request per line, held by requester |
| irq_en | input | 10 | Per-line enable |
| irq_lvl_sel | input | 10 | Per-line level select (0 = low, 1 = elevated) |
| reti | input | 1 | Return-from-interrupt pulse |
| ack | output | 1 | One-cycle grant pulse |
| vec_addr | output | 8 | Address of granted vector |
| svc_level | output | 2 | Current service level (top of stack) |

## Verification
The bench builds the block with its defaults: ten lines, two top-capable lines and a three-entry level stack. This is the smallest stack that holds a full low-high-highest nest. Those values let the bench fill the stack completely and unwind it to empty, including an extra return on the empty stack. They also let it reach both ends of the address range, 0x03 and 0x4B. With only two top-capable lines, the bench can set the select bit on line 0 and on line 9 and confirm that the same bit maps to different levels.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_IDLE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;
endpackage

// File: rtl/pvic_level_map.sv
module pvic_level_map
  import pvic_pkg::*;
#(
  parameter int NUM_VEC       = 10,
  parameter int TOP_VEC_COUNT = 2
) (
  input  logic [NUM_VEC-1:0]      sel,
  output logic [NUM_VEC-1:0][1:0] lvl
);
  // Per-line level: only the first TOP_VEC_COUNT lines may reach the top level.
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_map
    if (i < TOP_VEC_COUNT) begin : g_top
      assign lvl[i] = sel[i] ? LVL_TOP : LVL_LOW;
    end else begin : g_mid
      assign lvl[i] = sel[i] ? LVL_HIGH : LVL_LOW;
    end
  end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int NUM_VEC = 10,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0]      cand,
  input  logic [NUM_VEC-1:0][1:0] lvl,
  output lvl_t                    best_lvl,
  output logic [IDX_W-1:0]        best_idx
);
  // Scan upward; replace only on strictly greater level so the lowest
  // index survives a tie.
  always_comb begin
    best_lvl = LVL_IDLE;
    best_idx = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (cand[i] && (lvl[i] > best_lvl)) begin
        best_lvl = lvl[i];
        best_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pvic_level_stack.sv
module pvic_level_stack
  import pvic_pkg::*;
#(
  parameter int DEPTH  = 3,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output lvl_t top_lvl
);
  lvl_t             mem [DEPTH];
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= LVL_IDLE;
    end else if (pop) begin
      if (ptr != '0) ptr <= ptr - 1'b1;
    end else if (push && (ptr < PTR_W'(DEPTH))) begin
      mem[ptr] <= push_lvl;
      ptr      <= ptr + 1'b1;
    end
  end

  assign top_lvl = (ptr == '0) ? LVL_IDLE : mem[ptr - 1'b1];
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int NUM_VEC       = 10,
  parameter int TOP_VEC_COUNT = 2,
  parameter int STACK_DEPTH   = 3,
  parameter int ADDR_W        = 8,
  parameter int VEC_BASE      = 3,
  parameter int VEC_STRIDE    = 8,
  localparam int IDX_W        = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic [NUM_VEC-1:0] irq_en,
  input  logic [NUM_VEC-1:0] irq_lvl_sel,
  input  logic               reti,
  output logic               ack,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [1:0]         svc_level
);
  logic [NUM_VEC-1:0][1:0] line_lvl;
  logic [NUM_VEC-1:0]      cand;
  lvl_t                    best_lvl;
  logic [IDX_W-1:0]        best_idx;
  lvl_t                    cur_lvl;
  logic                    grant;

  assign cand = irq_req & irq_en;

  pvic_level_map #(.NUM_VEC(NUM_VEC), .TOP_VEC_COUNT(TOP_VEC_COUNT)) u_map (
    .sel (irq_lvl_sel),
    .lvl (line_lvl)
  );

  pvic_arbiter #(.NUM_VEC(NUM_VEC)) u_arb (
    .cand     (cand),
    .lvl      (line_lvl),
    .best_lvl (best_lvl),
    .best_idx (best_idx)
  );

  // A return takes the cycle; arbitration resumes on the next one.
  assign grant = glb_en && !reti && (best_lvl > cur_lvl);

  pvic_level_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (grant),
    .push_lvl (best_lvl),
    .pop      (reti),
    .top_lvl  (cur_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack      <= 1'b0;
      vec_addr <= '0;
    end else begin
      ack <= grant;
      if (grant) vec_addr <= ADDR_W'(VEC_BASE + int'(best_idx) * VEC_STRIDE);
    end
  end

  assign svc_level = cur_lvl;
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
  parameter int NUM_VEC    = 10,
  parameter int ADDR_W     = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               glb_en,
  input logic [NUM_VEC-1:0] irq_req,
  input logic [NUM_VEC-1:0] irq_en,
  input logic               reti,
  input logic               ack,
  input logic [ADDR_W-1:0]  vec_addr,
  input logic [1:0]         svc_level
);
  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_nest_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (svc_level > $past(svc_level)));

  assert_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !ack);

  assert_addr_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (((int'(vec_addr) - VEC_BASE) % VEC_STRIDE) == 0));

  assert_needs_enabled_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(|(irq_req & irq_en)));

  assert_pop_lowers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && svc_level != 2'd0) |=> (!ack && svc_level < $past(svc_level)));

  assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && svc_level == 2'd0) |=> (svc_level == 2'd0));
endmodule

bind pvic_top pvic_checker #(
  .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .irq_req(irq_req), .irq_en(irq_en),
  .reti(reti), .ack(ack), .vec_addr(vec_addr), .svc_level(svc_level)
);

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       glb_en = 1'b0;
  logic [9:0] irq_req = '0, irq_en = '0, irq_lvl_sel = '0;
  logic       reti = 1'b0;
  logic       ack;
  logic [7:0] vec_addr;
  logic [1:0] svc_level;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  pvic_top dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .irq_req(irq_req), .irq_en(irq_en),
    .irq_lvl_sel(irq_lvl_sel), .reti(reti), .ack(ack), .vec_addr(vec_addr),
    .svc_level(svc_level)
  );

  typedef struct packed {
    logic       g;
    logic [9:0] rq;
    logic [9:0] en;
    logic [9:0] sel;
    logic       rt;
    logic       e_ack;
    logic [7:0] e_vec;
    logic [1:0] e_lvl;
  } row_t;

  localparam int NROWS = 24;
  localparam row_t TBL [NROWS] = '{
    '{1'b1, 10'h000, 10'h3FF, 10'h000, 1'b0, 1'b0, 8'h00, 2'd0}, // 0  idle
    '{1'b1, 10'h020, 10'h3FF, 10'h000, 1'b0, 1'b1, 8'h2B, 2'd1}, // 1  R2 R8 low grant
    '{1'b1, 10'h020, 10'h3FF, 10'h000, 1'b0, 1'b0, 8'h00, 2'd1}, // 2  R6 equal held
    '{1'b1, 10'h0A0, 10'h3FF, 10'h080, 1'b0, 1'b1, 8'h3B, 2'd2}, // 3  R7 high nests
    '{1'b1, 10'h0A8, 10'h3FF, 10'h088, 1'b0, 1'b0, 8'h00, 2'd2}, // 4  R6 equal high held
    '{1'b1, 10'h002, 10'h3FF, 10'h002, 1'b0, 1'b1, 8'h0B, 2'd3}, // 5  R3 R7 highest
    '{1'b1, 10'h001, 10'h3FF, 10'h001, 1'b0, 1'b0, 8'h00, 2'd3}, // 6  R6 equal top held
    '{1'b1, 10'h001, 10'h3FF, 10'h001, 1'b1, 1'b0, 8'h00, 2'd2}, // 7  R9 pop, no grant
    '{1'b1, 10'h001, 10'h3FF, 10'h001, 1'b0, 1'b1, 8'h03, 2'd3}, // 8  R9 re-arbitrated
    '{1'b1, 10'h000, 10'h3FF, 10'h000, 1'b1, 1'b0, 8'h00, 2'd2}, // 9  R9
    '{1'b1, 10'h000, 10'h3FF, 10'h000, 1'b1, 1'b0, 8'h00, 2'd1}, // 10 R9
    '{1'b1, 10'h000, 10'h3FF, 10'h000, 1'b1, 1'b0, 8'h00, 2'd0}, // 11 R9
    '{1'b1, 10'h000, 10'h3FF, 10'h000, 1'b1, 1'b0, 8'h00, 2'd0}, // 12 R12 empty pop
    '{1'b1, 10'h214, 10'h3FF, 10'h210, 1'b0, 1'b1, 8'h23, 2'd2}, // 13 R4 R5 tie by index
    '{1'b1, 10'h000, 10'h3FF, 10'h000, 1'b1, 1'b0, 8'h00, 2'd0}, // 14
    '{1'b0, 10'h100, 10'h3FF, 10'h000, 1'b0, 1'b0, 8'h00, 2'd0}, // 15 R10 gated
    '{1'b0, 10'h100, 10'h3FF, 10'h000, 1'b0, 1'b0, 8'h00, 2'd0}, // 16 R10 gated
    '{1'b1, 10'h100, 10'h3FF, 10'h000, 1'b0, 1'b1, 8'h43, 2'd1}, // 17 R10 kept pending
    '{1'b1, 10'h000, 10'h3FF, 10'h000, 1'b1, 1'b0, 8'h00, 2'd0}, // 18
    '{1'b1, 10'h001, 10'h3FE, 10'h000, 1'b0, 1'b0, 8'h00, 2'd0}, // 19 R11 disabled line
    '{1'b1, 10'h201, 10'h3FE, 10'h201, 1'b0, 1'b1, 8'h4B, 2'd2}, // 20 R3 R11 last vector high
    '{1'b1, 10'h000, 10'h3FF, 10'h000, 1'b1, 1'b0, 8'h00, 2'd0}, // 21
    '{1'b1, 10'h003, 10'h3FF, 10'h002, 1'b0, 1'b1, 8'h0B, 2'd3}, // 22 R4 level beats index
    '{1'b1, 10'h000, 10'h3FF, 10'h000, 1'b1, 1'b0, 8'h00, 2'd0}  // 23
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ack", {7'd0, ack}, 8'd0);
    check("R1 vec", vec_addr, 8'd0);
    check("R1 lvl", {6'd0, svc_level}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 lvl after release", {6'd0, svc_level}, 8'd0);

    for (int r = 0; r < NROWS; r++) begin
      glb_en = TBL[r].g; irq_req = TBL[r].rq; irq_en = TBL[r].en;
      irq_lvl_sel = TBL[r].sel; reti = TBL[r].rt;
      @(negedge clk);
      check($sformatf("row %0d ack", r), {7'd0, ack}, {7'd0, TBL[r].e_ack});
      check($sformatf("row %0d svc_level", r), {6'd0, svc_level}, {6'd0, TBL[r].e_lvl});
      if (TBL[r].e_ack) check($sformatf("row %0d vec_addr", r), vec_addr, TBL[r].e_vec);
    end

    // R8: held request at a higher level pulses ack once only
    glb_en = 1; irq_en = '1; irq_lvl_sel = 10'h004; irq_req = 10'h004; reti = 0;
    @(negedge clk);
    check("R8 first ack", {7'd0, ack}, 8'd1);
    check("R2 vec line 2", vec_addr, 8'h13);
    check("R3 line2 high", {6'd0, svc_level}, 8'd2);
    @(negedge clk);
    check("R8 no repeat", {7'd0, ack}, 8'd0);

    // R1: reset mid-service clears stack and outputs
    rst_n = 0; irq_req = '0;
    @(negedge clk);
    check("R1 mid reset lvl", {6'd0, svc_level}, 8'd0);
    check("R1 mid reset vec", vec_addr, 8'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after reset", {7'd0, ack}, 8'd0);

    finish_run();
  end
endmodule